// File: doc/BRIEF.md
# Bus command FIFO engine

This block sits between a host register interface and the link layer of a two-wire audio bus. Software queues register-access commands for peripheral devices by writing packed 32-bit command words into a write-command queue or a read-command queue. The engine takes one command at a time from these queues and presents its decoded fields to the link layer. It then waits for a pass/fail response. A failed attempt is reissued until a configurable retry budget runs out. Read responses are returned through a read-data queue that the host drains.

Software throttles itself by reading the queue occupancy counts and comparing them with the depths reported in a read-only parameter word. Completion and error conditions are gathered into a sticky 17-bit interrupt status register. That register has a per-bit mask and a write-one-to-clear acknowledge. Its masked OR drives one interrupt line, which can run as a level or as a single-cycle pulse.

Host register offsets (4-bit address): 0 parameters (read-only), 1 occupancy status (read-only), 2 configuration, 3 interrupt status (read-only), 4 interrupt mask, 5 interrupt clear (write-only), 6 write-command push, 7 read-command push, 8 read-data pop. A host read returns its value on `host_rdata` one clock after `host_rd_en`. Unused offsets read as zero.

Top module: `bcmd_engine`

## Requirements
- R1: A command word is decoded as register address in bits 15:0, transaction ID in bits 19:16, device address in bits 23:20 and payload in bits 31:24 (write data for a write command, read length for a read command). While a command is presented, `cmd_addr`, `cmd_id`, `cmd_dev` and `cmd_payload` carry these fields, and `cmd_rd` is 1 for a command taken from the read-command queue.
- R2: `cmd_bcast` is high exactly when the presented device address is 0xF.
- R3: Writing offset 6 or 7 queues the word in first-in, first-out order. A push into a full queue is dropped. It sets status bit 6 for the write-command queue and bit 4 for the read-command queue. A read response that arrives while the read-data queue is full is dropped and also sets bit 4.
- R4: Offset 1 reports the write-command queue occupancy in bits 12:8 and the read-command queue occupancy in bits 26:22. All other bits are zero. A command leaves its queue only when it completes.
- R5: Offset 0 reports the write-command queue depth in bits 14:10 and the read-command queue depth in bits 19:15. All other bits are zero.
- R6: Configuration bits 2:0 hold a retry budget N, with reset value 3. An attempt that receives a fail response is reissued, with a fresh one-cycle `cmd_valid`, up to N times. When attempt 1+N also fails, the command is discarded and status bit 7 is set. An attempt that receives a pass response completes the command, and no further attempt follows.
- R7: A command with ID 0xF that completes with a pass response sets status bit 10. Commands with IDs 0 to 14 never set it.
- R8: A passing read command pushes `rsp_data` into the read-data queue. A host read of offset 8 pops the oldest entry. A pop of an empty queue returns zero and sets status bit 5.
- R9: Only one command is in flight at a time. When the engine selects its next command and both queues hold entries, the write-command queue goes first.
- R10: Status bits are sticky and are also set by the matching bits of `link_evt` (bit 14 reports bus reset finished). Writing ones to offset 5 clears the matching bits. A bit set in the same cycle as its clear stays set.
- R11: `irq` is the OR of the status bits ANDed with the mask at offset 4. When configuration bit 3 is 1, `irq` is instead high for one cycle each time that masked OR rises.
- R12: After reset the queues are empty, status and mask are zero, the retry budget is 3, the interrupt is in level mode, and `cmd_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after the read strobe |
| cmd_valid | output | 1 | One-cycle strobe starting an attempt |
| cmd_rd | output | 1 | Presented command is a read |
| cmd_bcast | output | 1 | Presented command targets all devices |
| cmd_addr | output | 16 | Presented register address |
| cmd_id | output | 4 | Presented transaction ID |
| cmd_dev | output | 4 | Presented device address |
| cmd_payload | output | 8 | Write data or read length |
| rsp_valid | input | 1 | Link layer response strobe |
| rsp_ok | input | 1 | Response is a pass |
| rsp_data | input | 32 | Read data carried with a passing read response |
| link_evt | input | 17 | Link-side event pulses merged into status |
| irq | output | 1 | Interrupt line |

## Verification
The bench aims at the retry boundary. A command that fails exactly N times must still pass on its last attempt. A command that fails N+1 times must stop with the error bit set. An off-by-one in the budget shows up as a missing or extra `cmd_valid` strobe, or as a wrong error bit. Budget 0 is covered too. The bench also checks that the special-ID bit is raised only on a pass and never on an exhausted command. It fills the write-command queue past its depth and drains it, so a design that wrapped its pointers wrongly or accepted the extra word would show a wrong count or an out-of-order address. It reads an empty data queue, overflows the data queue, and checks that the write queue wins over an older read once the bus is free. It also checks that pulse mode yields a one-cycle `irq`.

// File: rtl/bcmd_pkg.sv
// Shared constants and types for the bus command FIFO engine.
// Assumes a 4-bit host offset space and a 17-source interrupt vector.
package bcmd_pkg;

    localparam int NUM_SRC = 17;
    localparam int HADDR_W = 4;

    // Host register offsets
    localparam logic [HADDR_W-1:0] A_PARAM  = 4'd0;
    localparam logic [HADDR_W-1:0] A_STAT   = 4'd1;
    localparam logic [HADDR_W-1:0] A_CFG    = 4'd2;
    localparam logic [HADDR_W-1:0] A_ISTAT  = 4'd3;
    localparam logic [HADDR_W-1:0] A_IMASK  = 4'd4;
    localparam logic [HADDR_W-1:0] A_ICLR   = 4'd5;
    localparam logic [HADDR_W-1:0] A_WRCMD  = 4'd6;
    localparam logic [HADDR_W-1:0] A_RDCMD  = 4'd7;
    localparam logic [HADDR_W-1:0] A_RDDATA = 4'd8;

    // Interrupt source bit positions
    localparam int IRQ_RD_OVF   = 4;
    localparam int IRQ_RD_UNF   = 5;
    localparam int IRQ_WR_OVF   = 6;
    localparam int IRQ_CMD_ERR  = 7;
    localparam int IRQ_SPECIAL  = 10;

    localparam logic [3:0] SPECIAL_ID = 4'hF;
    localparam logic [3:0] BCAST_DEV  = 4'hF;
    localparam logic [2:0] RETRY_RST  = 3'd3;

    // Packed command word, most significant field first
    typedef struct packed {
        logic [7:0]  payload;
        logic [3:0]  dev;
        logic [3:0]  id;
        logic [15:0] addr;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bcmd_fifo.sv
// Synchronous first-in first-out queue with occupancy count.
// A push into a full queue is dropped and flagged on `drop`; a pop of an
// empty queue is ignored. Assumes DEPTH is a power of two, at least 2.
module bcmd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty,
    output logic                         drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          accept, take;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign drop   = push && full;
    assign dout   = mem[rptr_q];

    // Storage write on an accepted push
    always_ff @(posedge clk) begin
        if (accept) mem[wptr_q] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
        end else begin
            if (accept) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (take)   rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    fifo_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));
    // R3
    fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));

endmodule

// File: rtl/bcmd_seq.sv
// Command sequencer: selects the next command (write queue first), issues
// one attempt strobe, waits for the link response, reissues on failure
// while the retry budget lasts, then retires the command.
// Assumes the link answers every attempt with exactly one rsp_valid.
module bcmd_seq
    import bcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_empty,
    input  logic       rd_empty,
    input  cmd_word_t  wr_head,
    input  cmd_word_t  rd_head,
    input  logic [2:0] retry_lim,
    input  logic       rsp_valid,
    input  logic       rsp_ok,
    output logic       cmd_valid,
    output logic       cmd_sel_rd,
    output cmd_word_t  cmd_word,
    output logic       pop_wr,
    output logic       pop_rd,
    output logic       done_err,
    output logic       done_special,
    output logic       data_push
);
    seq_state_e state_q, state_d;
    logic       sel_q, sel_d;
    logic [2:0] tries_q, tries_d;
    logic       finish, failed;

    // Next-state, attempt counting and retirement decision
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        tries_d = tries_q;
        finish  = 1'b0;
        failed  = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                tries_d = '0;
                if (!wr_empty) begin
                    sel_d   = 1'b0;
                    state_d = SQ_ISSUE;
                end else if (!rd_empty) begin
                    sel_d   = 1'b1;
                    state_d = SQ_ISSUE;
                end
            end
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_ok) begin
                        finish  = 1'b1;
                        state_d = SQ_IDLE;
                    end else if (tries_q < retry_lim) begin
                        tries_d = tries_q + 1'b1;
                        state_d = SQ_ISSUE;
                    end else begin
                        finish  = 1'b1;
                        failed  = 1'b1;
                        state_d = SQ_IDLE;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sel_q   <= 1'b0;
            tries_q <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            tries_q <= tries_d;
        end
    end

    assign cmd_valid    = (state_q == SQ_ISSUE);
    assign cmd_sel_rd   = sel_q;
    assign cmd_word     = sel_q ? rd_head : wr_head;
    assign pop_wr       = finish && !sel_q;
    assign pop_rd       = finish && sel_q;
    assign done_err     = finish && failed;
    assign done_special = finish && !failed && (cmd_word.id == SPECIAL_ID);
    assign data_push    = finish && !failed && sel_q;

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6
    reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && rsp_valid && !rsp_ok && tries_q < retry_lim) |=> cmd_valid);
    // R6
    give_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && rsp_valid && !rsp_ok && tries_q >= retry_lim) |=> (state_q == SQ_IDLE));
    // R9
    write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && !wr_empty) |=> (cmd_valid && !cmd_sel_rd));

endmodule

// File: rtl/bcmd_irq.sv
// Interrupt status collector: sticky status bits with write-one-to-clear
// (set wins), per-bit mask, level or single-cycle pulse output.
module bcmd_irq #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    input  logic         pulse_mode,
    output logic [N-1:0] status,
    output logic         irq
);
    logic lvl, lvl_q;

    assign lvl = |(status & mask);
    assign irq = pulse_mode ? (lvl && !lvl_q) : lvl;

    // Sticky status update
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Previous masked level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((status & $past(clr_vec & ~set_vec)) == '0));
    // R10
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
    // R11
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && irq) |=> (!irq || !pulse_mode));

endmodule

// File: rtl/bcmd_engine.sv
// Top of the bus command FIFO engine: host register decode, the write and
// read command queues, the read-data queue, the sequencer and the
// interrupt collector. Assumes queue depths of at most 31 so that the
// 5-bit count and depth fields hold them, and DATA_W of at most 32.
module bcmd_engine
    import bcmd_pkg::*;
#(
    parameter int WR_DEPTH   = 8,
    parameter int RD_DEPTH   = 8,
    parameter int DATA_DEPTH = 8,
    parameter int DATA_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [3:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               cmd_valid,
    output logic               cmd_rd,
    output logic               cmd_bcast,
    output logic [15:0]        cmd_addr,
    output logic [3:0]         cmd_id,
    output logic [3:0]         cmd_dev,
    output logic [7:0]         cmd_payload,
    input  logic               rsp_valid,
    input  logic               rsp_ok,
    input  logic [DATA_W-1:0]  rsp_data,
    input  logic [16:0]        link_evt,
    output logic               irq
);
    localparam int WCW = $clog2(WR_DEPTH+1);
    localparam int RCW = $clog2(RD_DEPTH+1);
    localparam int DCW = $clog2(DATA_DEPTH+1);

    logic [2:0]          retry_q;
    logic                pulse_q;
    logic [NUM_SRC-1:0]  mask_q, status, set_vec, clr_vec;

    logic                wr_push, rd_push, data_pop, underflow;
    logic [31:0]         wr_dout, rd_dout;
    logic [WCW-1:0]      wr_cnt;
    logic [RCW-1:0]      rd_cnt;
    logic [DCW-1:0]      data_cnt;
    logic                wr_full, wr_empty, wr_drop;
    logic                rd_full, rd_empty, rd_drop;
    logic [DATA_W-1:0]   data_dout;
    logic                data_full, data_empty, data_drop;

    cmd_word_t           cur_word;
    logic                pop_wr, pop_rd, done_err, done_special, data_push;
    logic [31:0]         rd_mux, param_word, stat_word;

    assign wr_push   = host_wr_en && (host_addr == A_WRCMD);
    assign rd_push   = host_wr_en && (host_addr == A_RDCMD);
    assign data_pop  = host_rd_en && (host_addr == A_RDDATA);
    assign underflow = data_pop && data_empty;
    assign clr_vec   = (host_wr_en && host_addr == A_ICLR) ? host_wdata[NUM_SRC-1:0] : '0;

    // Configuration and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= RETRY_RST;
            pulse_q <= 1'b0;
            mask_q  <= '0;
        end else if (host_wr_en) begin
            if (host_addr == A_CFG) begin
                retry_q <= host_wdata[2:0];
                pulse_q <= host_wdata[3];
            end
            if (host_addr == A_IMASK) mask_q <= host_wdata[NUM_SRC-1:0];
        end
    end

    bcmd_fifo #(.W(32), .DEPTH(WR_DEPTH)) u_wr_q (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .din(host_wdata),
        .pop(pop_wr), .dout(wr_dout), .count(wr_cnt), .full(wr_full),
        .empty(wr_empty), .drop(wr_drop)
    );

    bcmd_fifo #(.W(32), .DEPTH(RD_DEPTH)) u_rd_q (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .din(host_wdata),
        .pop(pop_rd), .dout(rd_dout), .count(rd_cnt), .full(rd_full),
        .empty(rd_empty), .drop(rd_drop)
    );

    bcmd_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data_q (
        .clk(clk), .rst_n(rst_n), .push(data_push), .din(rsp_data),
        .pop(data_pop), .dout(data_dout), .count(data_cnt), .full(data_full),
        .empty(data_empty), .drop(data_drop)
    );

    bcmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_empty(wr_empty), .rd_empty(rd_empty),
        .wr_head(cmd_word_t'(wr_dout)), .rd_head(cmd_word_t'(rd_dout)),
        .retry_lim(retry_q), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .cmd_valid(cmd_valid), .cmd_sel_rd(cmd_rd), .cmd_word(cur_word),
        .pop_wr(pop_wr), .pop_rd(pop_rd), .done_err(done_err),
        .done_special(done_special), .data_push(data_push)
    );

    // Gather interrupt set events from the queues, sequencer and link
    always_comb begin
        set_vec = link_evt;
        set_vec[IRQ_RD_OVF]  = link_evt[IRQ_RD_OVF] | rd_drop | data_drop;
        set_vec[IRQ_RD_UNF]  = link_evt[IRQ_RD_UNF] | underflow;
        set_vec[IRQ_WR_OVF]  = link_evt[IRQ_WR_OVF] | wr_drop;
        set_vec[IRQ_CMD_ERR] = link_evt[IRQ_CMD_ERR] | done_err;
        set_vec[IRQ_SPECIAL] = link_evt[IRQ_SPECIAL] | done_special;
    end

    bcmd_irq #(.N(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask(mask_q), .pulse_mode(pulse_q), .status(status), .irq(irq)
    );

    assign cmd_addr    = cur_word.addr;
    assign cmd_id      = cur_word.id;
    assign cmd_dev     = cur_word.dev;
    assign cmd_payload = cur_word.payload;
    assign cmd_bcast   = (cur_word.dev == BCAST_DEV);

    // Parameter and occupancy words
    always_comb begin
        param_word        = '0;
        param_word[14:10] = 5'(WR_DEPTH);
        param_word[19:15] = 5'(RD_DEPTH);
        stat_word         = '0;
        stat_word[12:8]   = 5'(wr_cnt);
        stat_word[26:22]  = 5'(rd_cnt);
    end

    // Host read multiplexer
    always_comb begin
        case (host_addr)
            A_PARAM:  rd_mux = param_word;
            A_STAT:   rd_mux = stat_word;
            A_CFG:    rd_mux = {28'd0, pulse_q, retry_q};
            A_ISTAT:  rd_mux = 32'(status);
            A_IMASK:  rd_mux = 32'(mask_q);
            A_RDDATA: rd_mux = data_empty ? 32'd0 : 32'(data_dout);
            default:  rd_mux = 32'd0;
        endcase
    end

    // Registered host read data
    always_ff @(posedge clk) begin
        if (!rst_n)          host_rdata <= '0;
        else if (host_rd_en) host_rdata <= rd_mux;
    end

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pop && data_empty) |=> (host_rdata == 32'd0 && status[IRQ_RD_UNF]));
    // R5
    param_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_addr == A_PARAM) |=> (host_rdata[14:10] == 5'(WR_DEPTH)));

endmodule

// File: tb/sim_bcmd_engine.sv
module sim_bcmd_engine;
    localparam int DEP = 8;
    localparam logic [3:0] O_PARAM = 0, O_STAT = 1, O_CFG = 2, O_ISTAT = 3,
                           O_IMASK = 4, O_ICLR = 5, O_WR = 6, O_RD = 7, O_DATA = 8;

    // {retry[3], nfail[3], is_read, word[32], rsp data[32]}
    localparam logic [70:0] VECS [8] = '{
        {3'd3, 3'd0, 1'b0, 32'h5A230120, 32'h00000000},
        {3'd3, 3'd0, 1'b1, 32'h04170033, 32'hCAFE0001},
        {3'd3, 3'd0, 1'b0, 32'h83FF0060, 32'h00000000},
        {3'd3, 3'd2, 1'b0, 32'h11300200, 32'h00000000},
        {3'd3, 3'd3, 1'b0, 32'h224E0301, 32'h00000000},
        {3'd3, 3'd5, 1'b0, 32'h33250044, 32'h00000000},
        {3'd0, 3'd1, 1'b1, 32'h01690010, 32'h12345678},
        {3'd2, 3'd1, 1'b1, 32'h025F0021, 32'h0BADF00D}
    };

    logic clk = 0, rst_n = 0;
    logic host_wr_en = 0, host_rd_en = 0;
    logic [3:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic cmd_valid, cmd_rd, cmd_bcast, irq;
    logic [15:0] cmd_addr;
    logic [3:0] cmd_id, cmd_dev;
    logic [7:0] cmd_payload;
    logic rsp_valid = 0, rsp_ok = 0;
    logic [31:0] rsp_data = 0;
    logic [16:0] link_evt = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bcmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_bcast(cmd_bcast),
        .cmd_addr(cmd_addr), .cmd_id(cmd_id), .cmd_dev(cmd_dev),
        .cmd_payload(cmd_payload), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_data(rsp_data), .link_evt(link_evt), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd_en = 1; host_addr = a;
        @(negedge clk);
        host_rd_en = 0;
        d = host_rdata;
    endtask

    task automatic wait_issue(output bit found);
        for (int k = 0; k < 60 && !cmd_valid; k++) @(negedge clk);
        found = cmd_valid;
    endtask

    task automatic respond(input bit ok, input logic [31:0] d);
        @(negedge clk);
        rsp_valid = 1; rsp_ok = ok; rsp_data = d;
        @(negedge clk);
        rsp_valid = 0; rsp_ok = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit found;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R12 / R5: reset state and parameter word
        chk(!cmd_valid && !irq, "R12 idle outputs", {30'd0, cmd_valid, irq}, 0);
        hr(O_PARAM, rd);
        chk(rd == ((DEP << 15) | (DEP << 10)), "R5 param word", rd, (DEP << 15) | (DEP << 10));
        hr(O_STAT, rd);  chk(rd == 0, "R12 R4 empty counts", rd, 0);
        hr(O_CFG, rd);   chk(rd == 3, "R12 cfg reset", rd, 3);
        hr(O_ISTAT, rd); chk(rd == 0, "R12 status reset", rd, 0);
        hr(O_IMASK, rd); chk(rd == 0, "R12 mask reset", rd, 0);

        // Vector table: R1 R2 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            logic [2:0] rt, nf;
            logic isr;
            logic [31:0] w, dd;
            int att;
            bit err, sp;
            {rt, nf, isr, w, dd} = VECS[v];
            err = (nf > rt);
            att = err ? int'(rt) + 1 : int'(nf) + 1;
            sp  = (w[19:16] == 4'hF) && !err;
            hw(O_CFG, {29'd0, rt});
            hw(O_ICLR, 32'h1FFFF);
            hw(isr ? O_RD : O_WR, w);
            for (int a = 0; a < att; a++) begin
                wait_issue(found);
                chk(found, $sformatf("R6 attempt %0d of vec %0d", a, v), a, att);
                if (a == 0) begin
                    chk({cmd_payload, cmd_dev, cmd_id, cmd_addr} == w, "R1 fields",
                        {cmd_payload, cmd_dev, cmd_id, cmd_addr}, w);
                    chk(cmd_rd == isr, "R1 read flag", cmd_rd, isr);
                    chk(cmd_bcast == (w[23:20] == 4'hF), "R2 broadcast", cmd_bcast, w[23:20] == 4'hF);
                end
                respond(a >= int'(nf), dd);
            end
            found = 0;
            for (int k = 0; k < 6; k++) begin
                if (cmd_valid) found = 1;
                @(negedge clk);
            end
            chk(!found, "R6 no extra attempt", found, 0);
            hr(O_ISTAT, rd);
            chk(rd[7] == err, "R6 error bit", rd[7], err);
            chk(rd[10] == sp, "R7 special bit", rd[10], sp);
            if (isr) begin
                hr(O_DATA, rd);
                chk(rd == (err ? 32'd0 : dd), "R8 read data", rd, err ? 32'd0 : dd);
            end
        end

        // R3 R4: write queue overflow and in-order drain
        hw(O_CFG, 3);
        hw(O_ICLR, 32'h1FFFF);
        hw(O_IMASK, 32'h40);
        for (int i = 0; i < 9; i++) hw(O_WR, {8'(i), 4'd1, 4'd1, 16'(i)});
        hr(O_STAT, rd);
        chk(rd == (32'd8 << 8), "R4 write count full", rd, 32'd8 << 8);
        hr(O_ISTAT, rd);
        chk(rd[6] == 1'b1, "R3 write overflow bit", rd[6], 1);
        chk(irq == 1'b1, "R11 level irq", irq, 1);
        chk(cmd_addr == 16'd0, "R3 head order 0", cmd_addr, 0);
        respond(1, 0);
        for (int i = 1; i < 8; i++) begin
            wait_issue(found);
            chk(found && cmd_addr == 16'(i), "R3 drain order", cmd_addr, i);
            respond(1, 0);
        end
        hr(O_STAT, rd);
        chk(rd == 0, "R4 drained", rd, 0);

        // R9 R4: write queue wins over an older read
        hw(O_WR, 32'h0010000A);
        wait_issue(found);
        hw(O_RD, 32'h0110000B);
        hw(O_WR, 32'h0010000C);
        hr(O_STAT, rd);
        chk(rd == ((32'd2 << 8) | (32'd1 << 22)), "R4 both counts", rd, (32'd2 << 8) | (32'd1 << 22));
        respond(1, 0);
        wait_issue(found);
        chk(found && !cmd_rd && cmd_addr == 16'h000C, "R9 write first", {cmd_rd, cmd_addr}, 16'h000C);
        respond(1, 0);
        wait_issue(found);
        chk(found && cmd_rd && cmd_addr == 16'h000B, "R9 read after", {cmd_rd, cmd_addr}, 32'h1000B);
        respond(1, 32'h77);
        hr(O_DATA, rd);

        // R11 R8: pulse mode on an empty-queue pop
        hw(O_CFG, 32'hB);
        hw(O_ICLR, 32'h1FFFF);
        hw(O_IMASK, 32'h20);
        hr(O_DATA, rd);
        chk(rd == 0, "R8 empty pop returns zero", rd, 0);
        chk(irq == 1'b1, "R11 pulse high", irq, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R11 pulse one cycle", irq, 0);
        hw(O_CFG, 3);
        chk(irq == 1'b1, "R11 level after mode change", irq, 1);
        hw(O_IMASK, 0);
        chk(irq == 1'b0, "R11 mask gates", irq, 0);
        hw(O_IMASK, 32'h20);
        hw(O_ICLR, 32'h20);
        hr(O_ISTAT, rd);
        chk(rd[5] == 1'b0 && irq == 1'b0, "R10 clear", rd, 0);

        // R10: link event merge
        @(negedge clk); link_evt = 17'h4000;
        @(negedge clk); link_evt = 0;
        hr(O_ISTAT, rd);
        chk(rd[14] == 1'b1, "R10 link event", rd[14], 1);

        // R3 R8: read-data queue overflow
        hw(O_ICLR, 32'h1FFFF);
        for (int i = 0; i < 9; i++) begin
            hw(O_RD, {8'd1, 4'd2, 4'd3, 16'(i)});
            wait_issue(found);
            respond(1, 32'h100 + i);
        end
        hr(O_ISTAT, rd);
        chk(rd[4] == 1'b1, "R3 data overflow bit", rd[4], 1);
        hr(O_DATA, rd);
        chk(rd == 32'h100, "R8 data order", rd, 32'h100);
        for (int i = 1; i < 8; i++) hr(O_DATA, rd);
        chk(rd == 32'h107, "R3 last kept entry", rd, 32'h107);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule